// File: doc/BRIEF.md
# CAN Controller Sleep Handshake

This block runs the low-power sleep entry and exit for a CAN protocol controller whose register interface and bit engine sit in two separate clock domains. Software writes a sleep request bit in the register domain. That request crosses into the CAN domain through a two-flop synchroniser. The CAN side then waits for any frame that is being sent or received to finish before it goes to sleep. The sleep state crosses back through a second synchroniser and becomes the acknowledge that software polls.

While asleep, the block drops the clock enable of the CAN-side engine. This freezes frame handling, receive buffer transfers and the bus-off recovery count. It holds the transmit line recessive. What it does with the receive line depends on the wake-up enable. When wake-up is disabled, the line is forced recessive internally and bus traffic cannot end sleep. When wake-up is enabled, a dominant level ends sleep: the request bit is cleared and a single-cycle wake interrupt is raised in the register domain. Software can also leave sleep at any time by clearing the request.

A global power-down input overrides all of this and parks the CAN side in a powered-down state until it is released.

Top module: `can_sleep_hs`

## Requirements
- R1: After reset, sleep_req, sleep_ack and wake_irq are 0, can_clk_en is 1 and tx_hold_rec is 0.
- R2: While tx_busy or rx_busy is 1, the CAN side does not enter sleep and sleep_ack stays 0. Once both are 0, sleep is entered and sleep_ack rises.
- R3: With the bus idle, a write of 1 (sleep_req_wr=1, sleep_req_wdata=1) makes sleep_ack rise within 20 reg_clk cycles.
- R4: While asleep, can_clk_en is 0 and tx_hold_rec is 1.
- R5: While asleep with wake_en=0, a dominant rx_pin (0) is ignored: rx_int stays 1, sleep_ack stays 1 and no wake_irq occurs.
- R6: While asleep with wake_en=1, a dominant rx_pin raises wake_irq for exactly one reg_clk cycle. It also clears sleep_req and makes sleep_ack fall, and can_clk_en returns to 1.
- R7: Writing 0 to the request while asleep makes sleep_ack fall without any wake_irq.
- R8: sleep_ack falls only after the CAN side has left sleep: in the cycle it falls, can_clk_en is already 1.
- R9: While deep_pd is 1, can_clk_en is 0, tx_hold_rec is 1, rx_int is 1 and sleep_ack is 0, whatever the request and wake_en. After release, a pending request is served normally.
- R10: If a request write and a bus wake-up clear land in the same reg_clk cycle, the clear wins for that cycle. A write of 1 in the next cycle sets the request again, and sleep is re-entered.
- R11: While awake, rx_int follows rx_pin and tx_hold_rec is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register-domain clock |
| reg_rst_n | input | 1 | Register-domain synchronous reset, active low |
| sleep_req_wr | input | 1 | Write strobe for the sleep request bit |
| sleep_req_wdata | input | 1 | Value written to the request bit (1 = request sleep) |
| wake_en | input | 1 | Wake-up on bus activity enable |
| sleep_req | output | 1 | Current sleep request bit |
| sleep_ack | output | 1 | Synchronised sleep acknowledge |
| wake_irq | output | 1 | One-cycle pulse on bus wake-up |
| can_clk | input | 1 | CAN-domain clock |
| can_rst_n | input | 1 | CAN-domain synchronous reset, active low |
| tx_busy | input | 1 | Transmitter is sending a frame |
| rx_busy | input | 1 | Receiver is taking in a frame |
| rx_pin | input | 1 | Receive line, 0 = dominant |
| deep_pd | input | 1 | Global power-down, CAN domain |
| can_clk_en | output | 1 | Clock enable for the CAN-side engine |
| tx_hold_rec | output | 1 | Force transmit line recessive |
| rx_int | output | 1 | Receive line as seen by the engine |

## Verification
A request write from software and the register-side clear caused by a bus wake-up can fall in the same reg_clk cycle. The bench provokes this by holding the write strobe at 1 with data 1 across the whole wake-up. When wake_irq appears, it checks that the request reads 0 in the next cycle and 1 in the cycle after. The scoreboard then expects the wake event and the acknowledge fall in that one cycle, followed by a fresh acknowledge rise, in that order.

// File: rtl/can_slp_pkg.sv
// Shared types for the CAN sleep handshake.
// Assumes: used by the CAN-side state machine and its top level only.
package can_slp_pkg;

    // CAN-domain sleep state
    typedef enum logic [2:0] {
        ST_AWAKE = 3'd0,
        ST_DRAIN = 3'd1,
        ST_SLEEP = 3'd2,
        ST_WOKEN = 3'd3,
        ST_PDOWN = 3'd4
    } slp_state_t;

endpackage

// File: rtl/cs_sync.sv
// Multi-stage flop synchroniser for independent single-bit levels.
// Assumes: each bit is a slowly changing level. Bits are not coherent
// with each other. Synchronous active-low reset to RST_VAL.
module cs_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stage_q [STAGES];

    // first stage samples the foreign-domain level
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // further stages let metastability settle
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[LAST];

endmodule

// File: rtl/cs_can_fsm.sv
// CAN-domain sleep state machine.
// Defers sleep until the transmitter and receiver are idle. While asleep
// it gates the engine clock enable, holds transmit recessive and masks or
// watches the receive line. A bus wake-up is sent to the register domain
// as a toggle. The machine then waits for that toggle to be echoed back.
// Assumes: req_s, wen_s and echo_s are already synchronised. rx_pin and
// deep_pd are synchronous to can_clk.
module cs_can_fsm
    import can_slp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic wen_s,
    input  logic echo_s,
    input  logic tx_busy,
    input  logic rx_busy,
    input  logic rx_pin,
    input  logic deep_pd,
    output logic asleep,
    output logic wtog,
    output logic clk_en,
    output logic tx_hold,
    output logic rx_int
);
    slp_state_t state_q, state_d;
    logic       wtog_q, wtog_d;
    logic       idle, bus_wake;

    assign idle     = !tx_busy && !rx_busy;
    assign bus_wake = wen_s && !rx_pin;

    // next-state and wake toggle decision
    always_comb begin
        state_d = state_q;
        wtog_d  = wtog_q;
        if (deep_pd) begin
            state_d = ST_PDOWN;
        end else begin
            unique case (state_q)
                ST_AWAKE: if (req_s) state_d = ST_DRAIN;
                ST_DRAIN: begin
                    if (!req_s)    state_d = ST_AWAKE;
                    else if (idle) state_d = ST_SLEEP;
                end
                ST_SLEEP: begin
                    if (!req_s) begin
                        state_d = ST_AWAKE;
                    end else if (bus_wake) begin
                        state_d = ST_WOKEN;
                        wtog_d  = !wtog_q;
                    end
                end
                ST_WOKEN: if (echo_s == wtog_q) state_d = ST_AWAKE;
                ST_PDOWN: state_d = ST_AWAKE;
                default:  state_d = ST_AWAKE;
            endcase
        end
    end

    // state and toggle registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_AWAKE;
            wtog_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wtog_q  <= wtog_d;
        end
    end

    assign asleep  = (state_q == ST_SLEEP);
    assign wtog    = wtog_q;
    assign clk_en  = !(state_q == ST_SLEEP || state_q == ST_PDOWN);
    assign tx_hold = (state_q == ST_SLEEP || state_q == ST_PDOWN);
    assign rx_int  = (state_q == ST_PDOWN || (state_q == ST_SLEEP && !wen_s))
                     ? 1'b1 : rx_pin;

    // R2: never fall asleep while a frame is in flight
    assert_defer_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SLEEP && (tx_busy || rx_busy)) |=> state_q != ST_SLEEP);

    // R9: power-down overrides every other condition
    assert_pd_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        deep_pd |=> state_q == ST_PDOWN);

    // R5: masked bus activity cannot end sleep
    assert_masked_stay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && !wen_s && req_s && !deep_pd) |=> state_q == ST_SLEEP);

    // R6: an enabled dominant level leaves sleep and flips the toggle
    assert_bus_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && wen_s && req_s && !rx_pin && !deep_pd)
        |=> (state_q == ST_WOKEN && wtog_q != $past(wtog_q)));

endmodule

// File: rtl/cs_reg_side.sv
// Register-domain half of the sleep handshake.
// Holds the request bit, presents the synchronised acknowledge, and turns
// each change of the wake toggle into a one-cycle interrupt that also
// clears the request. The wake clear wins over a write in the same cycle.
// Assumes: ack_s and wtog_s are already synchronised into reg_clk.
module cs_reg_side (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wdata,
    input  logic ack_s,
    input  logic wtog_s,
    output logic req,
    output logic ack,
    output logic irq,
    output logic echo
);
    logic req_q;
    logic seen_q;
    logic wake_now;

    assign wake_now = (wtog_s != seen_q);

    // request bit: bus wake clear has priority over software write
    always_ff @(posedge clk) begin
        if (!rst_n)        req_q <= 1'b0;
        else if (wake_now) req_q <= 1'b0;
        else if (wr)       req_q <= wdata;
    end

    // remember the last toggle value handled; this is also the echo
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= wtog_s;
    end

    assign req  = req_q;
    assign ack  = ack_s;
    assign irq  = wake_now;
    assign echo = seen_q;

    // R6: a wake event leaves the request cleared
    assert_wake_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !req_q);

    // R6: the interrupt is a single-cycle pulse
    assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10: a write with no wake event takes effect next cycle
    assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !irq) |=> req_q == $past(wdata));

endmodule

// File: rtl/can_sleep_hs.sv
// Top level of the CAN sleep handshake.
// Crosses request, wake enable and toggle echo into the CAN domain, and
// crosses the sleep state and the wake toggle back to the register domain.
// Assumes: two unrelated clocks, each with its own synchronous active-low
// reset. rx_pin and deep_pd are synchronous to can_clk.
module can_sleep_hs #(
    parameter int SYNC_STAGES = 2
) (
    input  logic reg_clk,
    input  logic reg_rst_n,
    input  logic sleep_req_wr,
    input  logic sleep_req_wdata,
    input  logic wake_en,
    output logic sleep_req,
    output logic sleep_ack,
    output logic wake_irq,
    input  logic can_clk,
    input  logic can_rst_n,
    input  logic tx_busy,
    input  logic rx_busy,
    input  logic rx_pin,
    input  logic deep_pd,
    output logic can_clk_en,
    output logic tx_hold_rec,
    output logic rx_int
);
    localparam int TO_CAN_W = 3;
    localparam int TO_REG_W = 2;

    logic [TO_CAN_W-1:0] to_can_d, to_can_q;
    logic [TO_REG_W-1:0] to_reg_d, to_reg_q;
    logic                req_bit, echo_bit;
    logic                asleep_c, wtog_c;

    assign to_can_d = {echo_bit, wake_en, req_bit};

    cs_sync #(.W(TO_CAN_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_can (
        .clk   (can_clk),
        .rst_n (can_rst_n),
        .d     (to_can_d),
        .q     (to_can_q)
    );

    cs_can_fsm u_fsm (
        .clk     (can_clk),
        .rst_n   (can_rst_n),
        .req_s   (to_can_q[0]),
        .wen_s   (to_can_q[1]),
        .echo_s  (to_can_q[2]),
        .tx_busy (tx_busy),
        .rx_busy (rx_busy),
        .rx_pin  (rx_pin),
        .deep_pd (deep_pd),
        .asleep  (asleep_c),
        .wtog    (wtog_c),
        .clk_en  (can_clk_en),
        .tx_hold (tx_hold_rec),
        .rx_int  (rx_int)
    );

    assign to_reg_d = {wtog_c, asleep_c};

    cs_sync #(.W(TO_REG_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_reg (
        .clk   (reg_clk),
        .rst_n (reg_rst_n),
        .d     (to_reg_d),
        .q     (to_reg_q)
    );

    cs_reg_side u_reg (
        .clk    (reg_clk),
        .rst_n  (reg_rst_n),
        .wr     (sleep_req_wr),
        .wdata  (sleep_req_wdata),
        .ack_s  (to_reg_q[0]),
        .wtog_s (to_reg_q[1]),
        .req    (req_bit),
        .ack    (sleep_ack),
        .irq    (wake_irq),
        .echo   (echo_bit)
    );

    assign sleep_req = req_bit;

endmodule

// File: tb/can_sleep_hs_tb.sv
// Scoreboard bench: test tasks push expected register-side events, and a
// monitor pops and compares them as the design produces them.
module can_sleep_hs_tb;
    localparam int EV_WAKE = 0;
    localparam int EV_RISE = 1;
    localparam int EV_FALL = 2;

    logic reg_clk = 0, can_clk = 0;
    logic reg_rst_n = 0, can_rst_n = 0;
    logic sleep_req_wr = 0, sleep_req_wdata = 0, wake_en = 0;
    logic tx_busy = 0, rx_busy = 0, rx_pin = 1, deep_pd = 0;
    logic sleep_req, sleep_ack, wake_irq, can_clk_en, tx_hold_rec, rx_int;

    int  total = 0, bad = 0;
    bit  done = 0;
    int  exp_q[$];
    logic prev_ack = 0;

    always #5 reg_clk = ~reg_clk;
    always #7 can_clk = ~can_clk;

    can_sleep_hs u_dut (
        .reg_clk(reg_clk), .reg_rst_n(reg_rst_n),
        .sleep_req_wr(sleep_req_wr), .sleep_req_wdata(sleep_req_wdata),
        .wake_en(wake_en), .sleep_req(sleep_req), .sleep_ack(sleep_ack),
        .wake_irq(wake_irq), .can_clk(can_clk), .can_rst_n(can_rst_n),
        .tx_busy(tx_busy), .rx_busy(rx_busy), .rx_pin(rx_pin),
        .deep_pd(deep_pd), .can_clk_en(can_clk_en),
        .tx_hold_rec(tx_hold_rec), .rx_int(rx_int)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic sb_event(input int ev, input string tag);
        if (exp_q.size() == 0) begin
            check(0, {tag, " unexpected event"}, ev, -1);
        end else begin
            int e = exp_q.pop_front();
            check(e == ev, {tag, " event order"}, ev, e);
        end
    endtask

    // monitor: detect wake pulses and acknowledge edges
    always @(negedge reg_clk) begin
        if (reg_rst_n) begin
            if (wake_irq) sb_event(EV_WAKE, "R6");
            if (sleep_ack && !prev_ack) sb_event(EV_RISE, "R2/R3");
            if (!sleep_ack && prev_ack) begin
                sb_event(EV_FALL, "R7");
                check(can_clk_en == 1'b1, "R8 clk_en at ack fall", can_clk_en, 1);
            end
            prev_ack <= sleep_ack;
        end
    end

    task automatic sb_drain(input string tag);
        int n = 0;
        while (exp_q.size() != 0 && n < 200) begin
            @(negedge reg_clk);
            n++;
        end
        check(exp_q.size() == 0, {tag, " expected events seen"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic write_req(input logic v);
        @(negedge reg_clk);
        sleep_req_wr = 1; sleep_req_wdata = v;
        @(negedge reg_clk);
        sleep_req_wr = 0;
    endtask

    task automatic regs(input int n);
        repeat (n) @(negedge reg_clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge reg_clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        regs(4);
        @(negedge can_clk); can_rst_n = 1;
        @(negedge reg_clk); reg_rst_n = 1;
        regs(1);
        // R1 reset state
        check(sleep_req == 0, "R1 sleep_req", sleep_req, 0);
        check(sleep_ack == 0, "R1 sleep_ack", sleep_ack, 0);
        check(wake_irq == 0, "R1 wake_irq", wake_irq, 0);
        check(can_clk_en == 1, "R1 can_clk_en", can_clk_en, 1);
        check(tx_hold_rec == 0, "R1 tx_hold_rec", tx_hold_rec, 0);

        // R11 awake receive path
        rx_pin = 0; #1;
        check(rx_int == 0, "R11 rx_int follows 0", rx_int, 0);
        rx_pin = 1; #1;
        check(rx_int == 1, "R11 rx_int follows 1", rx_int, 1);

        // R3 idle entry
        exp_q.push_back(EV_RISE);
        write_req(1);
        regs(20);
        check(sleep_ack == 1, "R3 ack within 20 cycles", sleep_ack, 1);
        sb_drain("R3");
        check(can_clk_en == 0, "R4 clk_en gated", can_clk_en, 0);
        check(tx_hold_rec == 1, "R4 tx held recessive", tx_hold_rec, 1);

        // R5 masked bus activity
        @(negedge can_clk); rx_pin = 0;
        regs(30); #1;
        check(rx_int == 1, "R5 rx_int masked", rx_int, 1);
        check(sleep_ack == 1, "R5 still asleep", sleep_ack, 1);
        @(negedge can_clk); rx_pin = 1;
        regs(4);

        // R7 exit by clearing request
        exp_q.push_back(EV_FALL);
        write_req(0);
        sb_drain("R7");
        regs(5);
        check(can_clk_en == 1, "R7 awake again", can_clk_en, 1);

        // R2 deferral on transmit
        tx_busy = 1;
        exp_q.push_back(EV_RISE);
        write_req(1);
        regs(30);
        check(sleep_ack == 0, "R2 no ack while tx_busy", sleep_ack, 0);
        check(can_clk_en == 1, "R2 engine runs while tx_busy", can_clk_en, 1);
        @(negedge can_clk); tx_busy = 0;
        sb_drain("R2 tx");
        exp_q.push_back(EV_FALL);
        write_req(0);
        sb_drain("R2 tx exit");

        // R2 deferral on receive
        rx_busy = 1;
        exp_q.push_back(EV_RISE);
        write_req(1);
        regs(30);
        check(sleep_ack == 0, "R2 no ack while rx_busy", sleep_ack, 0);
        @(negedge can_clk); rx_busy = 0;
        sb_drain("R2 rx");

        // R6 bus wake-up with enable
        wake_en = 1;
        regs(8);
        exp_q.push_back(EV_WAKE);
        exp_q.push_back(EV_FALL);
        @(negedge can_clk); rx_pin = 0;
        begin
            int n = 0;
            while (!wake_irq && n < 100) begin @(negedge reg_clk); n++; end
        end
        @(negedge can_clk); rx_pin = 1;
        regs(1);
        check(wake_irq == 0, "R6 irq single cycle", wake_irq, 0);
        check(sleep_req == 0, "R6 request cleared", sleep_req, 0);
        sb_drain("R6");
        regs(10);
        check(can_clk_en == 1, "R6 engine running", can_clk_en, 1);

        // R10 write and wake clear in the same cycle
        exp_q.push_back(EV_RISE);
        write_req(1);
        sb_drain("R10 setup");
        exp_q.push_back(EV_WAKE);
        exp_q.push_back(EV_FALL);
        exp_q.push_back(EV_RISE);
        @(negedge reg_clk); sleep_req_wr = 1; sleep_req_wdata = 1;
        @(negedge can_clk); rx_pin = 0;
        begin
            int n = 0;
            while (!wake_irq && n < 100) begin @(negedge reg_clk); n++; end
        end
        rx_pin = 1;
        @(negedge reg_clk);
        check(sleep_req == 0, "R10 clear wins", sleep_req, 0);
        @(negedge reg_clk);
        check(sleep_req == 1, "R10 write lands next cycle", sleep_req, 1);
        sleep_req_wr = 0;
        sb_drain("R10");
        check(sleep_ack == 1, "R10 asleep again", sleep_ack, 1);
        exp_q.push_back(EV_FALL);
        write_req(0);
        sb_drain("R10 exit");
        wake_en = 0;

        // R9 power-down overrides request
        @(negedge can_clk); deep_pd = 1; rx_pin = 0;
        write_req(1);
        regs(20); #1;
        check(can_clk_en == 0, "R9 clk_en off", can_clk_en, 0);
        check(tx_hold_rec == 1, "R9 tx held", tx_hold_rec, 1);
        check(rx_int == 1, "R9 rx forced", rx_int, 1);
        check(sleep_ack == 0, "R9 no ack in power-down", sleep_ack, 0);
        exp_q.push_back(EV_RISE);
        @(negedge can_clk); deep_pd = 0; rx_pin = 1;
        sb_drain("R9 release");
        exp_q.push_back(EV_FALL);
        write_req(0);
        sb_drain("R9 exit");

        regs(5);
        done = 1;
        finish_run();
    end
endmodule